// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block is the timekeeping core of a real-time clock. A single-cycle enable arrives once per period of a 32768 Hz time base, and each one advances a 48-bit tick count. Because 2^15 ticks make one second, count bits 47:15 are whole seconds and bits 14:0 are the fraction. Software sees the count as three 16-bit words on a plain word-wide register bus. It can read and overwrite each word on its own. A second set of three words holds a 48-bit compare value.

When a tick moves the count onto the compare value, a sticky alarm flag is set. Software clears the flag by writing a one to it. The interrupt output is the flag gated by an enable bit. The three count words cannot be read atomically. Software therefore reads all three twice and accepts the result only when both passes agree. This works because the count moves only on a tick or on a bus write.

The bus has a window select. Window 0 holds the count and compare words. Window 1 holds the flag and enable registers.

Top module: `tick_alarm_rtc`

## Requirements
- R1: After a synchronous active-low reset, the count, compare value, alarm flag and enable all read zero, and irq_o is low.
- R2: A tick_i pulse with no count-word write in the same cycle adds exactly one to the 48-bit count. The carry ripples across all three words, and all ones wraps to zero. Without a tick the count holds.
- R3: Window 0 holds the count words at byte offset 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). Seconds bit 0 therefore appears in bit 15 at 0x00, seconds bits 16:1 appear at 0x02, and seconds bits 32:17 appear at 0x04.
- R4: A write to a count word replaces only that word, and the new value is readable in the next cycle. In a cycle that has both a tick and a count-word write, the write wins and the tick is dropped. The next tick counts up from the written value.
- R5: The compare value can be read and written in window 0 at 0x08 (bits 15:0), 0x0A (bits 31:16) and 0x0C (bits 47:32).
- R6: The alarm flag is bit 0 of window 1 offset 0x1E. It sets at the clock edge where a tick takes the count to the compare value, and this includes a wrap to zero when the compare value is zero. A bus write that makes the count equal to the compare value does not set the flag. Once set, the flag stays set.
- R7: Writing 1 to bit 0 of the flag register clears the flag, and writing 0 has no effect. If a set and a clear happen in the same cycle, the set wins.
- R8: The enable is bit 0 of window 1 offset 0x1C. irq_o equals the flag ANDed with the enable.
- R9: Any address not listed above reads zero, and writes to it change nothing. The unused upper bits of the flag and enable registers read zero.
- R10: When no tick and no count write occur between them, two successive reads of the three count words return the same values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and core clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle enable per time-base period |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_win_i | input | 1 | Window select: 0 selects count and compare, 1 selects flag and enable |
| bus_addr_i | input | 5 | Byte offset inside the window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Most internal faults reach the ports within one cycle of the stimulus that triggers them. A wrong increment or a broken carry shows up in the next read of the count words. A missed or spurious match shows up on the flag and on irq_o at the first sampling point after the tick that should or should not have set it.

The bench sweeps every address of both windows after each scenario. A decode fault therefore appears as a non-zero read at an unmapped offset, or as a write landing in the wrong word. The carry and match sweeps place the compare value across all three words, so a fault confined to a single word slice is still exposed.

// File: rtl/tick_alarm_pkg.sv
// Shared register-select types and window offsets for the elapsed-time counter.
// Assumes at most 16 count words and byte-addressed 16-bit registers.
package tick_alarm_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_MATCH,
        SEL_FLAG,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e    sel;
        logic [3:0]  word;
    } reg_hit_t;

    localparam int unsigned WORD_STRIDE = 2;
    localparam int unsigned MATCH_BASE  = 8;
    localparam int unsigned ENABLE_OFF  = 28;
    localparam int unsigned FLAG_OFF    = 30;

endpackage

// File: rtl/tick_alarm_decode.sv
// Address decoder: maps window select and byte offset to a register kind
// and word index. Assumes NWORDS*WORD_STRIDE <= MATCH_BASE so the count and
// compare ranges cannot overlap. Odd offsets are unmapped.
module tick_alarm_decode
    import tick_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned NWORDS = 3
) (
    input  logic              win_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_hit_t          hit_o
);

    // Purpose: pick the single register that this access selects.
    always_comb begin
        hit_o = '{sel: SEL_NONE, word: 4'd0};
        if (!win_i) begin
            for (int k = 0; k < NWORDS; k++) begin
                if (addr_i == ADDR_W'(WORD_STRIDE * k)) begin
                    hit_o.sel  = SEL_COUNT;
                    hit_o.word = 4'(k);
                end
                if (addr_i == ADDR_W'(MATCH_BASE + WORD_STRIDE * k)) begin
                    hit_o.sel  = SEL_MATCH;
                    hit_o.word = 4'(k);
                end
            end
        end else if (addr_i == ADDR_W'(FLAG_OFF)) begin
            hit_o.sel = SEL_FLAG;
        end else if (addr_i == ADDR_W'(ENABLE_OFF)) begin
            hit_o.sel = SEL_ENABLE;
        end
    end

endmodule

// File: rtl/tick_alarm_counter.sv
// Tick counter: a CNT_W-bit count that advances on tick_i. Each WORD_W
// slice can be overwritten by the bus. A write takes priority over a tick
// in the same cycle. Assumes CNT_W is a multiple of WORD_W.
module tick_alarm_counter #(
    parameter  int unsigned CNT_W  = 48,
    parameter  int unsigned WORD_W = 16,
    localparam int unsigned NWORDS = CNT_W / WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [NWORDS-1:0] wr_strb_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  count_nxt_o,
    output logic              advance_o
);

    logic [CNT_W-1:0] count_q;

    assign advance_o = tick_i && !(|wr_strb_i);
    assign count_o   = count_q;

    // Purpose: form the next count from the increment, then overlay written words.
    always_comb begin
        count_nxt_o = advance_o ? count_q + CNT_W'(1) : count_q;
        for (int k = 0; k < NWORDS; k++) begin
            if (wr_strb_i[k]) begin
                count_nxt_o[k*WORD_W +: WORD_W] = wdata_i;
            end
        end
    end

    // Purpose: hold the count register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else begin
            count_q <= count_nxt_o;
        end
    end

endmodule

// File: rtl/tick_alarm_match.sv
// Alarm unit: holds the compare words, the sticky alarm flag and the
// interrupt enable. The flag sets only when a tick carries the count onto
// the compare value. Assumes advance_i/count_nxt_i come from the counter.
module tick_alarm_match #(
    parameter  int unsigned CNT_W  = 48,
    parameter  int unsigned WORD_W = 16,
    localparam int unsigned NWORDS = CNT_W / WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NWORDS-1:0] cmp_strb_i,
    input  logic              flag_wr_i,
    input  logic              en_wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              advance_i,
    input  logic [CNT_W-1:0]  count_nxt_i,
    output logic [CNT_W-1:0]  match_o,
    output logic              flag_o,
    output logic              enable_o,
    output logic              irq_o
);

    logic [WORD_W-1:0] match_words_q [NWORDS];
    logic              hit;

    for (genvar g = 0; g < NWORDS; g++) begin : g_pack
        assign match_o[g*WORD_W +: WORD_W] = match_words_q[g];
    end

    assign hit   = advance_i && (count_nxt_i == match_o);
    assign irq_o = flag_o && enable_o;

    // Purpose: store compare words written over the bus.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int k = 0; k < NWORDS; k++) match_words_q[k] <= '0;
        end else begin
            for (int k = 0; k < NWORDS; k++) begin
                if (cmp_strb_i[k]) match_words_q[k] <= wdata_i;
            end
        end
    end

    // Purpose: sticky alarm flag; a set beats a write-one-to-clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_o <= 1'b0;
        end else if (hit) begin
            flag_o <= 1'b1;
        end else if (flag_wr_i && wdata_i[0]) begin
            flag_o <= 1'b0;
        end
    end

    // Purpose: interrupt enable bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            enable_o <= 1'b0;
        end else if (en_wr_i) begin
            enable_o <= wdata_i[0];
        end
    end

endmodule

// File: rtl/tick_alarm_rtc.sv
// Top of the elapsed-time counter with alarm. Decodes the word bus, routes
// write strobes to the counter and alarm unit, and muxes read data.
// Assumes tick_i is a one-cycle pulse synchronous to clk_i.
module tick_alarm_rtc
    import tick_alarm_pkg::*;
#(
    parameter int unsigned CNT_W  = 48,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_win_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    localparam int unsigned NWORDS = CNT_W / WORD_W;

    reg_hit_t          hit;
    logic [NWORDS-1:0] cnt_strb;
    logic [NWORDS-1:0] cmp_strb;
    logic              flag_wr;
    logic              en_wr;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              advance;
    logic [CNT_W-1:0]  cmp_val;
    logic              flag;
    logic              enable;

    tick_alarm_decode #(
        .ADDR_W (ADDR_W),
        .NWORDS (NWORDS)
    ) u_decode (
        .win_i  (bus_win_i),
        .addr_i (bus_addr_i),
        .hit_o  (hit)
    );

    for (genvar g = 0; g < NWORDS; g++) begin : g_strb
        assign cnt_strb[g] = bus_wr_i && (hit.sel == SEL_COUNT) && (hit.word == 4'(g));
        assign cmp_strb[g] = bus_wr_i && (hit.sel == SEL_MATCH) && (hit.word == 4'(g));
    end
    assign flag_wr = bus_wr_i && (hit.sel == SEL_FLAG);
    assign en_wr   = bus_wr_i && (hit.sel == SEL_ENABLE);

    tick_alarm_counter #(
        .CNT_W  (CNT_W),
        .WORD_W (WORD_W)
    ) u_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .wr_strb_i   (cnt_strb),
        .wdata_i     (bus_wdata_i),
        .count_o     (cnt_val),
        .count_nxt_o (cnt_nxt),
        .advance_o   (advance)
    );

    tick_alarm_match #(
        .CNT_W  (CNT_W),
        .WORD_W (WORD_W)
    ) u_match (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmp_strb_i  (cmp_strb),
        .flag_wr_i   (flag_wr),
        .en_wr_i     (en_wr),
        .wdata_i     (bus_wdata_i),
        .advance_i   (advance),
        .count_nxt_i (cnt_nxt),
        .match_o     (cmp_val),
        .flag_o      (flag),
        .enable_o    (enable),
        .irq_o       (irq_o)
    );

    // Purpose: return the addressed register; unmapped offsets read zero.
    always_comb begin
        bus_rdata_o = '0;
        case (hit.sel)
            SEL_COUNT: begin
                for (int k = 0; k < NWORDS; k++) begin
                    if (hit.word == 4'(k)) bus_rdata_o = cnt_val[k*WORD_W +: WORD_W];
                end
            end
            SEL_MATCH: begin
                for (int k = 0; k < NWORDS; k++) begin
                    if (hit.word == 4'(k)) bus_rdata_o = cmp_val[k*WORD_W +: WORD_W];
                end
            end
            SEL_FLAG:   bus_rdata_o = WORD_W'(flag);
            SEL_ENABLE: bus_rdata_o = WORD_W'(enable);
            default:    bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tick_alarm_rtc_chk.sv
// Checker for tick_alarm_rtc: temporal properties on the count, the alarm
// flag and the interrupt. Attached to the top by the bind below.
module tick_alarm_rtc_chk #(
    parameter int unsigned CNT_W  = 48,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned NWORDS = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              bus_wr_i,
    input logic              bus_win_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [WORD_W-1:0] bus_wdata_i,
    input logic [NWORDS-1:0] cnt_strb,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  cmp_val,
    input logic              flag,
    input logic              irq_o
);

    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !(|cnt_strb)) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

    // R10
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !(|cnt_strb)) |=> $stable(cnt_val));

    // R6
    flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag) |-> ($past(tick_i) && (cnt_val == $past(cmp_val))));

    // R7
    flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag) |-> $past(bus_wr_i && bus_win_i &&
                              (bus_addr_i == ADDR_W'(30)) && bus_wdata_i[0]));

    // R8
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> flag);

endmodule

bind tick_alarm_rtc tick_alarm_rtc_chk #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .NWORDS (NWORDS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_win_i   (bus_win_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cnt_strb    (cnt_strb),
    .cnt_val     (cnt_val),
    .cmp_val     (cmp_val),
    .flag        (flag),
    .irq_o       (irq_o)
);

// File: tb/tick_alarm_rtc_tb.sv
// Self-checking bench for tick_alarm_rtc: a bench-side model of the count,
// compare value, flag and enable, with full address sweeps after each scenario.
module tick_alarm_rtc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_win = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] m_cnt = '0;
    logic [47:0] m_cmp = '0;
    bit          m_flag = 0;
    bit          m_en = 0;

    always #2 clk = ~clk;

    tick_alarm_rtc u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (bus_wr),
        .bus_win_i   (bus_win),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input bit win, input int a);
        if (!win) begin
            case (a)
                0:  return m_cnt[15:0];
                2:  return m_cnt[31:16];
                4:  return m_cnt[47:32];
                8:  return m_cmp[15:0];
                10: return m_cmp[31:16];
                12: return m_cmp[47:32];
                default: return 16'h0;
            endcase
        end
        if (a == 30) return {15'h0, m_flag};
        if (a == 28) return {15'h0, m_en};
        return 16'h0;
    endfunction

    // One clock: drive at a falling edge, let the rising edge act, update the model.
    task automatic step(input bit tk, input bit wr, input bit win, input int a, input logic [15:0] d);
        bit cnt_wr;
        bit set;
        logic [47:0] nxt;
        cnt_wr = wr && !win && (a == 0 || a == 2 || a == 4);
        tick = tk; bus_wr = wr; bus_win = win; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        tick = 0; bus_wr = 0;
        set = 0;
        if (cnt_wr) begin
            nxt = m_cnt;
            nxt[(a/2)*16 +: 16] = d;
            m_cnt = nxt;
        end else if (tk) begin
            m_cnt = m_cnt + 48'd1;
            set = (m_cnt == m_cmp);
        end
        if (wr && !win && (a == 8 || a == 10 || a == 12)) begin
            nxt = m_cmp;
            nxt[((a-8)/2)*16 +: 16] = d;
            m_cmp = nxt;
        end
        if (set) m_flag = 1;
        else if (wr && win && a == 30 && d[0]) m_flag = 0;
        if (wr && win && a == 28) m_en = d[0];
    endtask

    task automatic set_cnt(input logic [47:0] v);
        step(0, 1, 0, 0, v[15:0]);
        step(0, 1, 0, 2, v[31:16]);
        step(0, 1, 0, 4, v[47:32]);
    endtask

    task automatic set_cmp(input logic [47:0] v);
        step(0, 1, 0, 8, v[15:0]);
        step(0, 1, 0, 10, v[31:16]);
        step(0, 1, 0, 12, v[47:32]);
    endtask

    task automatic rd(input bit win, input int a, output logic [15:0] v);
        bus_win = win; bus_addr = 5'(a);
        #0.5;
        v = bus_rdata;
    endtask

    // Read every offset of both windows and compare with the model; re-align afterwards.
    task automatic sweep(input string tag);
        logic [15:0] v;
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < 32; a++) begin
                rd(w[0], a, v);
                chk($sformatf("%s win%0d addr%0d", tag, w, a), {32'h0, v}, {32'h0, exp_rd(w[0], a)});
            end
        end
        chk({tag, " irq R8"}, {47'h0, irq}, {47'h0, m_flag && m_en});
        @(negedge clk);
    endtask

    task automatic chk_flag(input string tag);
        logic [15:0] v;
        rd(1, 30, v);
        chk({tag, " flag"}, {32'h0, v}, {32'h0, exp_rd(1, 30)});
        chk({tag, " irq R8"}, {47'h0, irq}, {47'h0, m_flag && m_en});
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a0, a1, a2, b0, b1, b2;
        logic [47:0] vals [6];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R9: reset state of every register
        sweep("R1 reset");

        // R3 R5: word layout, seconds value 0x1_2345_6789 plus fraction 0x1ABC
        set_cnt({33'h1_2345_6789, 15'h1ABC});
        set_cmp(48'hA5A5_5A5A_0F0F);
        sweep("R3 R5 layout");
        rd(0, 0, a0);
        chk("R3 seconds bit0 at low bit15", {47'h0, a0[15]}, 48'd1);
        @(negedge clk);

        // R2: carry out of each word boundary, then full wrap onto compare zero
        for (int k = 1; k < 3; k++) begin
            set_cnt((48'd1 << (16*k)) - 48'd1);
            step(1, 0, 0, 0, 0);
            sweep($sformatf("R2 carry word%0d", k));
        end
        set_cmp(48'h0);
        set_cnt(48'hFFFF_FFFF_FFFF);
        step(1, 0, 0, 0, 0);
        sweep("R2 R6 wrap to zero");
        step(0, 1, 1, 30, 16'h1);

        // R6 R8: match sweep with compare placed in each word, enable toggled
        vals[0] = 48'h0000_0000_0005; vals[1] = 48'h0000_0001_0000;
        vals[2] = 48'h0000_0000_8000; vals[3] = 48'h0001_0000_0000;
        vals[4] = 48'h7FFF_0000_0002; vals[5] = 48'hFFFF_FFFF_FFFF;
        foreach (vals[i]) begin
            step(0, 1, 1, 28, {15'h0, i[0]});
            set_cmp(vals[i]);
            set_cnt(vals[i] - 48'd3);
            for (int t = 0; t < 3; t++) begin
                step(1, 0, 0, 0, 0);
                chk_flag($sformatf("R6 match%0d tick%0d", i, t));
            end
            sweep($sformatf("R6 after match%0d", i));
            // R6: flag stays set on a further tick
            step(1, 0, 0, 0, 0);
            chk_flag($sformatf("R6 sticky%0d", i));
            // R7: write 0 does nothing, write 1 clears
            step(0, 1, 1, 30, 16'hFFFE);
            chk_flag($sformatf("R7 write0 %0d", i));
            step(0, 1, 1, 30, 16'h0001);
            chk_flag($sformatf("R7 clear %0d", i));
        end

        // R6: writing the count equal to compare does not set the flag
        set_cmp(48'h0000_0042_0000);
        set_cnt(48'h0000_0042_0000);
        chk_flag("R6 write-equal no set");

        // R7: set and clear in the same cycle, set wins
        set_cnt(48'h0000_0041_FFFF);
        step(1, 0, 0, 0, 0);
        set_cnt(48'h0000_0041_FFFF);
        step(1, 1, 1, 30, 16'h0001);
        chk_flag("R7 set beats clear");
        step(0, 1, 1, 30, 16'h0001);

        // R4: write wins over a same-cycle tick, next tick counts from written value
        set_cnt(48'h0);
        step(1, 1, 0, 0, 16'h1234);
        sweep("R4 write over tick");
        step(1, 0, 0, 0, 0);
        sweep("R4 tick after write");
        step(0, 1, 0, 2, 16'hBEEF);
        sweep("R4 single word write");

        // R9: writes to unmapped offsets change nothing
        step(0, 1, 0, 6, 16'hFFFF);
        step(0, 1, 0, 14, 16'hFFFF);
        step(0, 1, 0, 16, 16'hFFFF);
        step(0, 1, 0, 3, 16'hFFFF);
        step(0, 1, 1, 0, 16'hFFFF);
        step(0, 1, 1, 29, 16'hFFFF);
        sweep("R9 unmapped writes");

        // R10: two passes over the count words without a tick agree
        rd(0, 0, a0); rd(0, 2, a1); rd(0, 4, a2);
        @(negedge clk); @(negedge clk);
        rd(0, 0, b0); rd(0, 2, b1); rd(0, 4, b2);
        chk("R10 repeat read", {b2, b1, b0}, {a2, a1, a0});
        chk("R10 repeat read model", {b2, b1, b0}, m_cnt);
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule